// File: doc/BRIEF.md
# Two-Digit Decimal Pending-Job Tally

This block keeps a running decimal tally, 00 to 99, of jobs that are waiting. One operator presses a button when a job arrives and the tally goes up by one. Another operator presses a button when a job is finished and the tally goes down by one. Both button lines reach the block already debounced. Inside the block each line passes through a two-flop synchroniser, and only its rising edge counts as a press.

Each press sets its own pending flag. A scheduler grants one pending flag per clock, so presses from both operators at the same moment are both applied, one after the other. When both flags are pending, the direction that was not served last goes first. The count is held as two BCD decades, and a carry or borrow from the units decade steps the tens decade. The count stops at 00 and at 99 and never wraps. A registered decoder drives each digit's active-high seven-segment pattern for a common-cathode display.

Top module: `bcd_tally_top`

## Requirements
- R1: `count_o` is packed BCD, with tens in bits 7:4 and units in bits 3:0. Each digit is always 0..9, so the value stays within 00..99.
- R2: Each accepted press on `inc_i` adds exactly one to the count. Each accepted press on `dec_i` subtracts exactly one. The count changes by at most one per clock.
- R3: A units digit stepping up from 9 to 0 carries one into the tens digit. A units digit stepping down from 0 to 9 borrows one from the tens digit.
- R4: A down press while the count is 00 leaves the count at 00.
- R5: An up press while the count is 99 leaves the count at 99.
- R6: A press is a rising edge on an input after a two-flop synchroniser. An input held high gives only one press. The count changes on the fourth rising clock edge after the input rises.
- R7: An up press and a down press in the same cycle are both applied, on two consecutive cycles. The count ends where it started.
- R8: When both directions are pending, the direction not served most recently is granted first. After reset the up direction has priority.
- R9: Each segment bus holds {g,f,e,d,c,b,a}, with bit 0 = a and 1 = segment lit. The digit codes are 0:3F 1:06 2:5B 3:4F 4:66 5:6D 6:7D 7:07 8:7F 9:6F (hex). A segment bus shows a new count one clock after `count_o` changes.
- R10: While `rst_ni` is low, asynchronously, the count is 00, both pending flags are cleared, and both segment buses show the digit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 1 | Debounced up button |
| dec_i | input | 1 | Debounced down button |
| count_o | output | 8 | Packed BCD count |
| seg_tens_o | output | 7 | Segment pattern of the tens digit |
| seg_units_o | output | 7 | Segment pattern of the units digit |

## Verification
Several internal faults show at the ports within one clock. A stuck pending flag, a scheduler that grants both directions at once, or a broken carry path makes `count_o` jump by more than one step, or show a non-decimal digit, on the edge where the step is applied. A wrong priority flag shows only in the order of the two steps after a simultaneous press, so the bench samples the intermediate value on the fourth and fifth edges. A pending flag that survives reset shows as an unexpected step a few cycles after reset is released.

// File: rtl/bcd_tally_pkg.sv
package bcd_tally_pkg;
  localparam int DIGIT_W  = 4;
  localparam int SEG_W    = 7;
  localparam int N_DIGITS = 2;
  localparam int COUNT_W  = DIGIT_W * N_DIGITS;

  typedef logic [DIGIT_W-1:0] bcd_t;
  typedef logic [SEG_W-1:0]   seg_t;

  // {g,f,e,d,c,b,a}, high = lit
  function automatic seg_t seg_of(bcd_t d);
    case (d)
      4'd0: seg_of = 7'h3F;
      4'd1: seg_of = 7'h06;
      4'd2: seg_of = 7'h5B;
      4'd3: seg_of = 7'h4F;
      4'd4: seg_of = 7'h66;
      4'd5: seg_of = 7'h6D;
      4'd6: seg_of = 7'h7D;
      4'd7: seg_of = 7'h07;
      4'd8: seg_of = 7'h7F;
      4'd9: seg_of = 7'h6F;
      default: seg_of = 7'h00;
    endcase
  endfunction
endpackage

// File: rtl/edge_sync.sv
module edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], d_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/req_scheduler.sv
module req_scheduler (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic up_rise_i,
  input  logic dn_rise_i,
  output logic grant_up_o,
  output logic grant_dn_o
);
  logic pend_up_q, pend_dn_q, last_up_q;

  // both pending: serve the one not served last
  always_comb begin
    grant_up_o = pend_up_q & (~pend_dn_q | ~last_up_q);
    grant_dn_o = pend_dn_q & ~grant_up_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_up_q <= 1'b0;
      pend_dn_q <= 1'b0;
      last_up_q <= 1'b0;
    end else begin
      pend_up_q <= (pend_up_q & ~grant_up_o) | up_rise_i;
      pend_dn_q <= (pend_dn_q & ~grant_dn_o) | dn_rise_i;
      if (grant_up_o | grant_dn_o) last_up_q <= grant_up_o;
    end
  end
endmodule

// File: rtl/bcd_decade.sv
module bcd_decade
  import bcd_tally_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  input  logic dec_i,
  output bcd_t digit_o,
  output logic carry_o,
  output logic borrow_o
);
  bcd_t digit_q;

  assign carry_o  = inc_i & (digit_q == 4'd9);
  assign borrow_o = dec_i & (digit_q == 4'd0);
  assign digit_o  = digit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       digit_q <= '0;
    else if (carry_o)  digit_q <= '0;
    else if (borrow_o) digit_q <= 4'd9;
    else if (inc_i)    digit_q <= digit_q + 4'd1;
    else if (dec_i)    digit_q <= digit_q - 4'd1;
  end
endmodule

// File: rtl/seg_reg.sv
module seg_reg
  import bcd_tally_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  bcd_t digit_i,
  output seg_t seg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seg_o <= seg_of(4'd0);
    else         seg_o <= seg_of(digit_i);
  end
endmodule

// File: rtl/bcd_tally_top.sv
module bcd_tally_top
  import bcd_tally_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       inc_i,
  input  logic       dec_i,
  output logic [7:0] count_o,
  output logic [6:0] seg_tens_o,
  output logic [6:0] seg_units_o
);
  logic up_rise, dn_rise, grant_up, grant_dn;
  logic at_max, at_min;
  logic [N_DIGITS:0] inc_chain, dec_chain;
  bcd_t digits [N_DIGITS];
  seg_t segs   [N_DIGITS];

  edge_sync #(.STAGES(SYNC_STAGES)) i_sync_up (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(inc_i), .rise_o(up_rise));
  edge_sync #(.STAGES(SYNC_STAGES)) i_sync_dn (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(dec_i), .rise_o(dn_rise));

  req_scheduler i_sched (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .up_rise_i(up_rise), .dn_rise_i(dn_rise),
    .grant_up_o(grant_up), .grant_dn_o(grant_dn));

  always_comb begin
    at_max = 1'b1;
    at_min = 1'b1;
    for (int k = 0; k < N_DIGITS; k++) begin
      at_max &= (digits[k] == 4'd9);
      at_min &= (digits[k] == 4'd0);
    end
  end

  // clamp: a grant at an end is consumed without a step
  assign inc_chain[0] = grant_up & ~at_max;
  assign dec_chain[0] = grant_dn & ~at_min;

  for (genvar k = 0; k < N_DIGITS; k++) begin : g_digit
    bcd_decade i_decade (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .inc_i(inc_chain[k]), .dec_i(dec_chain[k]),
      .digit_o(digits[k]),
      .carry_o(inc_chain[k+1]), .borrow_o(dec_chain[k+1]));
    seg_reg i_seg (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .digit_i(digits[k]), .seg_o(segs[k]));
    assign count_o[k*DIGIT_W +: DIGIT_W] = digits[k];
  end

  assign seg_units_o = segs[0];
  assign seg_tens_o  = segs[1];
endmodule

// File: rtl/bcd_tally_checker.sv
module bcd_tally_checker
  import bcd_tally_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] count_o,
  input logic [6:0] seg_tens_o,
  input logic [6:0] seg_units_o
);
  logic [6:0] bin;
  assign bin = 7'(count_o[7:4] * 4'd10) + 7'(count_o[3:0]);

  assert_digits_decimal_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count_o[3:0] <= 4'd9) && (count_o[7:4] <= 4'd9));

  assert_single_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bin == $past(bin)) || (bin == $past(bin) + 7'd1) || (bin + 7'd1 == $past(bin)));

  assert_no_underflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bin) == 7'd0) |-> (bin <= 7'd1));

  assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(bin) == 7'd99) |-> (bin >= 7'd98));

  assert_seg_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_units_o == seg_of($past(count_o[3:0]))) &&
    (seg_tens_o  == seg_of($past(count_o[7:4]))));
endmodule

bind bcd_tally_top bcd_tally_checker i_checker (.*);

// File: tb/test_bcd_tally_top.sv
module test_bcd_tally_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       inc_i = 1'b0;
  logic       dec_i = 1'b0;
  logic [7:0] count_o;
  logic [6:0] seg_tens_o, seg_units_o;

  int checks = 0;
  int errors = 0;
  int model  = 0;
  bit done   = 0;

  bcd_tally_top i_bcd_tally_top (.*);

  always #4 clk_i = ~clk_i;

  function automatic logic [7:0] to_bcd(int v);
    return {4'(v / 10), 4'(v % 10)};
  endfunction

  function automatic logic [6:0] seg_exp(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
      4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
      8: return 7'h7F; 9: return 7'h6F;
      default: return 7'h00;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic check_all(string tag, int v);
    check({tag, " count"}, count_o, to_bcd(v));
    check({tag, " seg units"}, seg_units_o, seg_exp(v % 10));
    check({tag, " seg tens"}, seg_tens_o, seg_exp(v / 10));
  endtask

  task automatic press(bit up, bit dn);
    @(negedge clk_i); inc_i = up; dec_i = dn;
    repeat (2) @(negedge clk_i);
    inc_i = 0; dec_i = 0;
    repeat (8) @(negedge clk_i);
    if (up && !dn && model < 99) model++;
    if (dn && !up && model > 0)  model--;
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1; model = 0;
    repeat (2) @(negedge clk_i);
  endtask

  task automatic t_reset_state();  // R10
    do_reset();
    check_all("R10 reset state", 0);
  endtask

  task automatic t_basic();  // R2, R9
    repeat (3) press(1, 0);
    check_all("R2 up x3", 3);
    press(0, 1);
    check_all("R2 down", 2);
    press(1, 0); press(1, 0);  // model 4
  endtask

  task automatic t_latency();  // R6
    @(negedge clk_i); inc_i = 1;
    repeat (3) @(negedge clk_i);
    check("R6 before 4th edge", count_o, to_bcd(model));
    @(negedge clk_i);
    check("R6 at 4th edge", count_o, to_bcd(model + 1));
    check("R9 seg lags count", seg_units_o, seg_exp(model % 10));
    @(negedge clk_i);
    check("R9 seg one later", seg_units_o, seg_exp((model + 1) % 10));
    repeat (20) @(negedge clk_i);  // still held
    inc_i = 0;
    repeat (8) @(negedge clk_i);
    model++;
    check("R6 held gives one step", count_o, to_bcd(model));
  endtask

  task automatic t_simul(int first_delta, string tag);  // R7, R8
    int start = model;
    @(negedge clk_i); inc_i = 1; dec_i = 1;
    repeat (2) @(negedge clk_i);
    inc_i = 0; dec_i = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    check({tag, " first step"}, count_o, to_bcd(start + first_delta));
    @(negedge clk_i);
    check("R7 both applied", count_o, to_bcd(start));
    repeat (6) @(negedge clk_i);
    check_all("R7 settled", start);
  endtask

  task automatic t_carry();  // R3
    while (model < 9) press(1, 0);
    check_all("R3 at 09", 9);
    press(1, 0);
    check_all("R3 carry 10", 10);
    press(0, 1);
    check_all("R3 borrow 09", 9);
  endtask

  task automatic t_top_clamp();  // R5
    while (model < 99) press(1, 0);
    check_all("R5 reached 99", 99);
    press(1, 0);
    check_all("R5 hold 99", 99);
    press(0, 1);
    check_all("R5 down from 99", 98);
  endtask

  task automatic t_bottom_clamp();  // R4, R1
    do_reset();
    press(0, 1);
    check_all("R4 hold 00", 0);
    press(1, 0);
    check("R1 packed bcd", count_o, 8'h01);
  endtask

  task automatic t_reset_clears();  // R10
    @(negedge clk_i); inc_i = 1;
    repeat (3) @(negedge clk_i);  // pending flag set at 3rd edge
    inc_i = 0; rst_ni = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    repeat (10) @(negedge clk_i);
    model = 0;
    check_all("R10 pending cleared", 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_simul(1, "R8 up first after reset");  // R8: from 00, up granted first
    t_basic();
    t_latency();                            // model 5, last served up
    t_simul(-1, "R8 down first");
    press(0, 1);                            // last served down
    t_simul(1, "R8 up first");
    t_carry();
    t_top_clamp();
    t_bottom_clamp();
    t_reset_clears();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule